// File: doc/BRIEF.md
# Filtered Dual Fault Monitor

This block watches two digital comparator results, each saying whether a monitored voltage sits above or below its reference. Every channel passes through a programmable glitch filter that only accepts a new level once it has persisted for a chosen number of clock samples. Each filtered channel is then read as an undervoltage or an overvoltage condition according to its own configuration bit. The two fault conditions are combined into one active-low fault output, and that output can be suppressed while the supply is being driven to its high or low margin.

A small status view holds two live fault bits and two latched fault bits. The latched bits are captured by one of two selectable events. The first is the leading edge of a channel fault. The second is an external ready line pulled low, which lets several monitors on a board take a snapshot together. The ready event is only armed by particular changes of the margin state. A clear strobe empties the latched bits.

Top module: `dual_fault_monitor`

## Requirements
- R1: Out of reset both filtered comparator states read 0 (input below reference), the latched bits are 0, and no latch event is generated from the reset state itself.
- R2: `cfg_filt_sel_i` picks the filter length L from parameters T0, T1, T2, T3 for codes 0, 1, 2, 3. A comparator level that differs from the filtered state must be sampled on L+1 consecutive clock edges, and it is accepted on the last of them.
- R3: A differing comparator level that lasts fewer than L+1 consecutive samples leaves the filtered state, and so the live bits, unchanged.
- R4: With `cfg_ov_i[i]`=1, channel i is in fault while its filtered input is above reference (1). With `cfg_ov_i[i]`=0 it is in fault while the filtered input is below reference (0). `stat_live_o[i]` shows that fault, with 1 meaning fault.
- R5: `fault_n_o` is 0 while any live bit is 1 and not masked, and 1 otherwise.
- R6: Margin states are encoded as off=0, nominal=1, high=2, low=3. When `cfg_mask_margin_i`=1 and the state is high or low, `fault_n_o` is held at 1 and the live bits still follow the channels. Off and nominal are never masked.
- R7: With `cfg_latch_ready_i`=0, `stat_latched_o[i]` is set on the clock edge after `stat_live_o[i]` goes from 0 to 1, and on no other event.
- R8: `stat_clr_i` clears the latched bits on the next edge, and a cleared bit stays 0 while its fault persists. A latch event on the same edge as the clear takes priority.
- R9: With `cfg_latch_ready_i`=1, a low `ready_i` copies the live bits into the latched bits once the monitor is armed. Arming happens when the margin state moves from off to nominal, high or low, from nominal to high or low, or from high or low to nominal. It is cleared by a capture, by any move to off, and by a move between high and low.
- R10: In ready mode, fault leading edges do not latch. In edge mode, `ready_i` has no effect on the latched bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_above_i | input | NCH (2) | Raw comparator results, 1 = input above reference |
| cfg_ov_i | input | NCH (2) | Per-channel sense, 1 = overvoltage, 0 = undervoltage |
| cfg_filt_sel_i | input | 2 | Filter length select, codes 0 to 3 |
| cfg_mask_margin_i | input | 1 | Suppress fault output in high and low margin states |
| cfg_latch_ready_i | input | 1 | Latch source, 0 = fault leading edge, 1 = ready line low |
| margin_i | input | 2 | Margin state: 0 off, 1 nominal, 2 high, 3 low |
| ready_i | input | 1 | Ready line read-back, low requests a snapshot |
| stat_clr_i | input | 1 | Clear strobe for the latched bits |
| fault_n_o | output | 1 | Active-low combined fault |
| stat_live_o | output | NCH (2) | Live fault bits |
| stat_latched_o | output | NCH (2) | Latched fault bits |

## Verification
The bench builds the block with filter lengths of 0, 2, 5 and 12 clock ticks instead of microsecond-scale defaults. Short filters make both sides of every acceptance boundary reachable in a few cycles: a pulse one sample short of L+1 and a level held for exactly L+1 samples. The zero-tick setting covers the single-sample case. A behavioural model tracks run lengths, the arming flag and the latch rules, and its outputs are compared on every clock across the margin-state sequences that arm and disarm the ready snapshot.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

   typedef enum logic [1:0] {
      MG_OFF  = 2'd0,
      MG_NOM  = 2'd1,
      MG_HIGH = 2'd2,
      MG_LOW  = 2'd3
   } margin_e;

   // True when a move from 'from_s' to 'to_s' arms the ready-line snapshot.
   function automatic logic arms_ready(input margin_e from_s, input margin_e to_s);
      logic ok;
      ok = 1'b0;
      case (from_s)
         MG_OFF:           ok = (to_s != MG_OFF);
         MG_NOM:           ok = (to_s == MG_HIGH) || (to_s == MG_LOW);
         MG_HIGH, MG_LOW:  ok = (to_s == MG_NOM);
         default:          ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/fmon_glitch_filter.sv
module fmon_glitch_filter #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned T0    = 0,
   parameter int unsigned T1    = 3,
   parameter int unsigned T2    = 8,
   parameter int unsigned T3    = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw_i,
   input  logic [1:0] sel_i,
   output logic       flt_o
);

   localparam bit BYPASS = (T0 == 0) && (T1 == 0) && (T2 == 0) && (T3 == 0);

   generate
      if (T3 >= (64'd1 << CNT_W)) begin : g_bad_width
         $error("fmon_glitch_filter: filter length exceeds counter width");
      end
   endgenerate

   logic flt_q;

   generate
      if (BYPASS) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flt_q <= 1'b0;
            else        flt_q <= raw_i;
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] lim;

         always_comb begin
            case (sel_i)
               2'd0:    lim = CNT_W'(T0);
               2'd1:    lim = CNT_W'(T1);
               2'd2:    lim = CNT_W'(T2);
               default: lim = CNT_W'(T3);
            endcase
         end

         // Counts edges on which raw differs from the accepted level.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flt_q <= 1'b0;
               cnt_q <= '0;
            end else if (raw_i == flt_q) begin
               cnt_q <= '0;
            end else if (cnt_q >= lim) begin
               flt_q <= raw_i;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         // R3: a run still short of the selected length cannot flip the state
         a_r3_short_run_held: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_i != flt_q && cnt_q < lim) |=> $stable(flt_q));
      end
   endgenerate

   // R2: agreement between raw and filtered level never moves the filter
   a_r2_steady_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_i == flt_q) |=> $stable(flt_q));

   assign flt_o = flt_q;

endmodule

// File: rtl/fmon_latch.sv
module fmon_latch
   import fmon_pkg::*;
#(
   parameter int unsigned NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] live_i,
   input  logic           src_ready_i,
   input  logic [1:0]     margin_i,
   input  logic           ready_i,
   input  logic           clr_i,
   output logic [NCH-1:0] lat_o
);

   logic [NCH-1:0] prev_q, lat_q, lat_d, rise;
   margin_e        ms_q, ms_in;
   logic           armed_q, armed_d, moved, capture;

   assign ms_in   = margin_e'(margin_i);
   assign moved   = (ms_in != ms_q);
   assign capture = src_ready_i && armed_q && !ready_i;
   assign rise    = live_i & ~prev_q;

   always_comb begin
      if (moved)        armed_d = arms_ready(ms_q, ms_in);
      else if (capture) armed_d = 1'b0;
      else              armed_d = armed_q;
   end

   always_comb begin
      if (src_ready_i) lat_d = capture ? live_i : (clr_i ? '0 : lat_q);
      else             lat_d = (clr_i ? '0 : lat_q) | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '1;
         lat_q   <= '0;
         ms_q    <= MG_OFF;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= live_i;
         lat_q   <= lat_d;
         ms_q    <= ms_in;
         armed_q <= armed_d;
      end
   end

   // R9: landing in the off state always leaves the snapshot disarmed
   a_r9_off_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_in == MG_OFF) |=> !armed_q);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chk
         // R7: a bit can only become latched while its channel is in fault
         a_r7_no_spurious_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (!live_i[i] && !lat_q[i]) |=> !lat_q[i]);
         // R8: clear in edge mode with no fresh leading edge empties the bit
         a_r8_clear_wins_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !src_ready_i && prev_q[i]) |=> !lat_q[i]);
      end
   endgenerate

   assign lat_o = lat_q;

endmodule

// File: rtl/dual_fault_monitor.sv
module dual_fault_monitor
   import fmon_pkg::*;
#(
   parameter int unsigned NCH = 2,
   parameter int unsigned T0  = 0,
   parameter int unsigned T1  = 3000,
   parameter int unsigned T2  = 8000,
   parameter int unsigned T3  = 24000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] cmp_above_i,
   input  logic [NCH-1:0] cfg_ov_i,
   input  logic [1:0]     cfg_filt_sel_i,
   input  logic           cfg_mask_margin_i,
   input  logic           cfg_latch_ready_i,
   input  logic [1:0]     margin_i,
   input  logic           ready_i,
   input  logic           stat_clr_i,
   output logic           fault_n_o,
   output logic [NCH-1:0] stat_live_o,
   output logic [NCH-1:0] stat_latched_o
);

   localparam int unsigned T_MAX = T3;
   localparam int unsigned CNT_W = (T_MAX < 1) ? 1 : $clog2(T_MAX + 1);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("dual_fault_monitor: NCH must be at least 1");
      end
      if (!(T0 <= T1 && T1 <= T2 && T2 <= T3)) begin : g_bad_order
         $error("dual_fault_monitor: filter lengths must be non-decreasing");
      end
   endgenerate

   logic [NCH-1:0] flt;
   logic [NCH-1:0] live;
   logic           masked;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         fmon_glitch_filter #(
            .CNT_W (CNT_W),
            .T0    (T0),
            .T1    (T1),
            .T2    (T2),
            .T3    (T3)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (cmp_above_i[i]),
            .sel_i (cfg_filt_sel_i),
            .flt_o (flt[i])
         );
         assign live[i] = cfg_ov_i[i] ? flt[i] : !flt[i];
      end
   endgenerate

   assign masked = cfg_mask_margin_i &&
                   ((margin_e'(margin_i) == MG_HIGH) || (margin_e'(margin_i) == MG_LOW));

   assign fault_n_o   = !((|live) && !masked);
   assign stat_live_o = live;

   fmon_latch #(
      .NCH (NCH)
   ) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .live_i      (live),
      .src_ready_i (cfg_latch_ready_i),
      .margin_i    (margin_i),
      .ready_i     (ready_i),
      .clr_i       (stat_clr_i),
      .lat_o       (stat_latched_o)
   );

   // R6: high or low margin with masking enabled never shows a fault
   a_r6_margin_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask_margin_i && margin_i[1]) |-> fault_n_o);

endmodule

// File: tb/dual_fault_monitor_tb.sv
`timescale 1ns/1ps
module dual_fault_monitor_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmp_above = 2'b00;
   logic [1:0] cfg_ov = 2'b01;
   logic [1:0] cfg_sel = 2'd1;
   logic       cfg_mask = 1'b0;
   logic       cfg_src = 1'b0;
   logic [1:0] margin = 2'd0;
   logic       ready = 1'b1;
   logic       clr = 1'b0;
   logic       fault_n;
   logic [1:0] live_o, lat_o;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   dual_fault_monitor #(
      .NCH (2), .T0 (0), .T1 (2), .T2 (5), .T3 (12)
   ) u_dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .cmp_above_i       (cmp_above),
      .cfg_ov_i          (cfg_ov),
      .cfg_filt_sel_i    (cfg_sel),
      .cfg_mask_margin_i (cfg_mask),
      .cfg_latch_ready_i (cfg_src),
      .margin_i          (margin),
      .ready_i           (ready),
      .stat_clr_i        (clr),
      .fault_n_o         (fault_n),
      .stat_live_o       (live_o),
      .stat_latched_o    (lat_o)
   );

   // ---------------- behavioural reference model ----------------
   bit [1:0] m_flt, m_prev, m_lat, m_ms;
   int       m_run [2];
   bit       m_arm;

   function automatic int len_of(input logic [1:0] s);
      case (s)
         2'd0: return 0;
         2'd1: return 2;
         2'd2: return 5;
         default: return 12;
      endcase
   endfunction

   function automatic bit [1:0] m_live(input bit [1:0] f);
      bit [1:0] r;
      for (int i = 0; i < 2; i++) r[i] = cfg_ov[i] ? f[i] : !f[i];
      return r;
   endfunction

   function automatic bit arm_ok(input bit [1:0] a, input bit [1:0] b);
      return (a == 2'd0 && b != 2'd0) || (a == 2'd1 && b >= 2'd2) ||
             (a >= 2'd2 && b == 2'd1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flt = '0; m_prev = 2'b11; m_lat = '0; m_ms = '0; m_arm = 0;
         m_run[0] = 0; m_run[1] = 0;
      end else begin
         bit [1:0] lv, nlat;
         bit cap, narm;
         lv  = m_live(m_flt);
         cap = cfg_src && m_arm && !ready;
         if (cfg_src) nlat = cap ? lv : (clr ? 2'b00 : m_lat);
         else         nlat = (clr ? 2'b00 : m_lat) | (lv & ~m_prev);
         if (margin != m_ms) narm = arm_ok(m_ms, margin);
         else if (cap)       narm = 0;
         else                narm = m_arm;
         for (int i = 0; i < 2; i++) begin
            if (cmp_above[i] != m_flt[i]) begin
               m_run[i] = m_run[i] + 1;
               if (m_run[i] >= len_of(cfg_sel) + 1) begin
                  m_flt[i] = cmp_above[i];
                  m_run[i] = 0;
               end
            end else begin
               m_run[i] = 0;
            end
         end
         m_prev = lv; m_lat = nlat; m_arm = narm; m_ms = margin;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // cycle compare against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit [1:0] lv;
         lv = m_live(m_flt);
         chk(cur_req, "cycle live", 32'(live_o), 32'(lv));
         chk(cur_req, "cycle latched", 32'(lat_o), 32'(m_lat));
         chk(cur_req, "cycle fault_n", 32'(fault_n),
             32'(!((|lv) && !(cfg_mask && margin >= 2'd2))));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1: ch0 OV (no fault at 0), ch1 UV (fault at 0)
      chk("R1", "reset live", 32'(live_o), 32'h2);
      chk("R1", "reset latched", 32'(lat_o), 32'h0);
      chk("R1", "reset fault_n", 32'(fault_n), 32'h0);

      cur_req = "R2";
      cmp_above[1] = 1'b1;           // L=2 -> accepted on third sample
      step(2);
      chk("R2", "ch1 before L+1", 32'(live_o), 32'h2);
      step(1);
      chk("R2", "ch1 at L+1", 32'(live_o), 32'h0);
      chk("R5", "no fault", 32'(fault_n), 32'h1);

      cur_req = "R3";
      cmp_above[0] = 1'b1; step(2); cmp_above[0] = 1'b0; step(4);
      chk("R3", "short pulse ch0", 32'(live_o[0]), 32'h0);

      cur_req = "R7";
      cmp_above[0] = 1'b1; step(3);
      chk("R4", "OV fault ch0", 32'(live_o), 32'h1);
      chk("R5", "fault_n low", 32'(fault_n), 32'h0);
      chk("R7", "not yet latched", 32'(lat_o), 32'h0);
      step(1);
      chk("R7", "latched after edge", 32'(lat_o), 32'h1);

      cur_req = "R8";
      clr = 1'b1; step(1); clr = 1'b0;
      chk("R8", "cleared while fault", 32'(lat_o), 32'h0);
      chk("R8", "fault still live", 32'(live_o[0]), 32'h1);
      step(3);
      chk("R8", "stays cleared", 32'(lat_o), 32'h0);

      cur_req = "R6";
      cfg_mask = 1'b1; margin = 2'd2; step(1);
      chk("R6", "masked high", 32'(fault_n), 32'h1);
      chk("R6", "live unaffected", 32'(live_o[0]), 32'h1);
      margin = 2'd3; step(1);
      chk("R6", "masked low", 32'(fault_n), 32'h1);
      margin = 2'd1; step(1);
      chk("R6", "nominal unmasked", 32'(fault_n), 32'h0);
      margin = 2'd0; step(1);
      chk("R6", "off unmasked", 32'(fault_n), 32'h0);
      cfg_mask = 1'b0;

      cur_req = "R10";
      margin = 2'd1; step(1);
      ready = 1'b0; step(1); ready = 1'b1;
      chk("R10", "ready ignored in edge mode", 32'(lat_o), 32'h0);

      cur_req = "R8";
      cmp_above[0] = 1'b0; step(3);
      chk("R8", "ch0 fault gone", 32'(live_o[0]), 32'h0);
      cmp_above[0] = 1'b1; step(3);
      chk("R8", "ch0 fault back", 32'(live_o[0]), 32'h1);
      clr = 1'b1; step(1); clr = 1'b0;
      chk("R8", "edge beats clear", 32'(lat_o[0]), 32'h1);

      cur_req = "R2";
      cfg_sel = 2'd0; cmp_above[1] = 1'b0; step(1);
      chk("R2", "L=0 single sample", 32'(live_o[1]), 32'h1);
      cmp_above[1] = 1'b1; step(1);
      chk("R2", "L=0 back", 32'(live_o[1]), 32'h0);

      cur_req = "R3";
      cfg_sel = 2'd3; cmp_above[1] = 1'b0; step(12);
      chk("R3", "L=12 one short", 32'(live_o[1]), 32'h0);
      step(1);
      chk("R2", "L=12 accepted", 32'(live_o[1]), 32'h1);
      step(1);

      cur_req = "R9";
      cfg_src = 1'b1; margin = 2'd0; cfg_sel = 2'd0; cmp_above[1] = 1'b1;
      step(1);
      clr = 1'b1; step(1); clr = 1'b0;
      chk("R9", "start empty", 32'(lat_o), 32'h0);
      chk("R9", "live pattern", 32'(live_o), 32'h1);
      margin = 2'd1; step(1);        // off -> nominal arms
      ready = 1'b0; step(1); ready = 1'b1;
      chk("R9", "snapshot off->nom", 32'(lat_o), 32'h1);
      clr = 1'b1; step(1); clr = 1'b0;
      ready = 1'b0; step(1); ready = 1'b1;
      chk("R9", "disarmed after capture", 32'(lat_o), 32'h0);
      margin = 2'd2; step(1); margin = 2'd3; step(1);
      ready = 1'b0; step(1); ready = 1'b1;
      chk("R9", "high->low disarms", 32'(lat_o), 32'h0);
      margin = 2'd0; step(1);
      ready = 1'b0; step(1); ready = 1'b1;
      chk("R9", "to off not honoured", 32'(lat_o), 32'h0);
      margin = 2'd2; step(1);
      ready = 1'b0; clr = 1'b1; step(1); ready = 1'b1; clr = 1'b0;
      chk("R9", "capture beats clear", 32'(lat_o), 32'h1);
      cmp_above[1] = 1'b0; step(1);
      margin = 2'd1; step(1);        // high -> nominal arms
      ready = 1'b0; step(1); ready = 1'b1;
      chk("R9", "snapshot high->nom", 32'(lat_o), 32'h3);

      cur_req = "R10";
      clr = 1'b1; step(1); clr = 1'b0;
      cmp_above[0] = 1'b0; step(1); cmp_above[0] = 1'b1; step(3);
      chk("R10", "edge ignored in ready mode", 32'(lat_o), 32'h0);
      chk("R4", "ch0 fault present", 32'(live_o[0]), 32'h1);

      step(2);
      finish_run();
   end

endmodule